// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream (bit clock, frame clock and one data line) into parallel 24-bit two's complement samples. It accepts I2S, left-justified and right-justified data with 24, 20, 18 or 16 bits, and TDM frames of 8 or 16 slots. A single shift engine handles every format. A 3-bit mode code selects the format. Two further inputs set the frame clock polarity and the bit clock sampling edge.

The block runs on a system clock that is much faster than the bit clock. It synchronizes the three serial lines and finds the bit clock edges itself. Each completed channel word leaves the block as a one-cycle strobe, with the 24-bit sample and its channel or slot index. In TDM mode the frame clock can be a 50/50 clock or a pulse one bit wide. Configuration inputs must stay constant while the block is out of reset.

Top module: `serial_audio_rx`

## Requirements
- R1: Mode code 000 (I2S): the MSB of a word is the bit on the first selected bit-clock edge after the one that sees the frame clock change level. The word closes when the next such delayed change is seen.
- R2: Mode code 001 (left-justified): the MSB is the bit on the edge that sees the frame clock change level. The word closes at the next change.
- R3: Mode codes 011, 100, 101 and 110 (right-justified, widths 24, 20, 18 and 16). Each half-frame is 32 bit clocks long. The word is the last W bits before the frame clock changes, with its LSB on the final edge of the half-frame.
- R4: A word shorter than 24 bits leaves the block left-aligned, with zeros below its LSB. Bits beyond the 24th of a word are discarded and change nothing.
- R5: Outside TDM, the reported channel is 0 for a word captured while the frame clock equals the frame polarity input, and 1 otherwise. So with polarity 0, left (0) is captured while the frame clock is low.
- R6: Mode code 010 (TDM): a frame starts when the frame clock moves to its active level (low for polarity 0, high for polarity 1). Slot 0's MSB is on the next selected edge. Slots are 32 bits long and the channel index is the slot number. The return to the inactive level inside a frame is ignored, so a 50/50 clock and a one-bit pulse both work.
- R7: With the 16-slot select at 0, slots 0 to 7 are reported; with it at 1, slots 0 to 15. Slots that arrive after the last one in a frame are not reported.
- R8: With bit-clock polarity 0, data is sampled on rising bit-clock edges. With polarity 1, it is sampled on falling edges.
- R9: The valid strobe is high for exactly one system clock per completed word, never on two consecutive cycles. Sample and channel are held between strobes.
- R10: After reset the strobe is low and the sample and channel outputs are zero. The first sampled edge only records the frame clock level, and the partial word in progress at reset is never reported.
- R11: Mode code 111 is reserved and produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Format code (see R1, R2, R3, R6, R11) |
| cfg_fs_pol | input | 1 | Frame clock polarity |
| cfg_bclk_pol | input | 1 | Bit clock sampling edge select |
| cfg_tdm16 | input | 1 | 1 = 16-slot TDM frame, 0 = 8-slot frame |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame clock or frame pulse |
| sdata_i | input | 1 | Serial data, MSB first |
| smp_data | output | 24 | Received sample, left-aligned |
| smp_chan | output | 4 | Channel (0/1) or TDM slot index |
| smp_valid | output | 1 | One-cycle strobe per completed word |

## Verification
Two events can fall on the same bit-clock edge: the close of one word, which produces the strobe, and the start of the next word, which loads that edge's bit as the new MSB. The stimulus makes them coincide in every stream. The sharpest cases are I2S with 24-bit half-frames, where the old LSB sits on the edge that follows the frame clock change, and the TDM 32-bit slot boundaries. Each emitted sample and index is compared with words built in the bench. A wrong bit on either side of the shared edge shows up as a corrupted MSB or LSB in the compared sample.

// File: rtl/sar_pkg.sv
// Shared types for the serial audio receiver.
// Holds the format codes and helpers that decode the right-justified widths.
package sar_pkg;

    typedef enum logic [2:0] {
        FMT_I2S  = 3'd0,
        FMT_LJ   = 3'd1,
        FMT_TDM  = 3'd2,
        FMT_RJ24 = 3'd3,
        FMT_RJ20 = 3'd4,
        FMT_RJ18 = 3'd5,
        FMT_RJ16 = 3'd6,
        FMT_RSV  = 3'd7
    } fmt_e;

    // True for the four right-justified codes.
    function automatic logic is_rj(fmt_e m);
        return (m == FMT_RJ24) || (m == FMT_RJ20) || (m == FMT_RJ18) || (m == FMT_RJ16);
    endfunction

    // Word width carried by a right-justified code.
    function automatic int unsigned rj_width(fmt_e m);
        case (m)
            FMT_RJ20: return 20;
            FMT_RJ18: return 18;
            FMT_RJ16: return 16;
            default:  return 24;
        endcase
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
// Synchronizes bit clock, frame clock and data into the system clock domain.
// It also flags the selected bit-clock edge.
// Assumes each bit-clock level lasts at least SYNC_STAGES system clocks.
// All three lines go through chains of equal depth, so they stay aligned.
module sar_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fs_i,
    input  logic sd_i,
    input  logic bclk_pol,
    output logic samp_edge,
    output logic fs_lvl,
    output logic sd_bit
);
    localparam int SIG_N = 3;

    logic [SIG_N-1:0] raw;
    logic [SIG_N-1:0] synced;
    logic             bclk_q;

    assign raw = {sd_i, fs_i, bclk_i};

    for (genvar s = 0; s < SIG_N; s++) begin : g_sync
        logic [SYNC_STAGES-1:0] ch;
        // Shift chain that moves one line into the system clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) ch <= '0;
            else        ch <= {ch[SYNC_STAGES-2:0], raw[s]};
        end
        assign synced[s] = ch[SYNC_STAGES-1];
    end

    // Delays the synchronized bit clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= synced[0];
    end

    assign samp_edge = bclk_pol ? (bclk_q & ~synced[0]) : (synced[0] & ~bclk_q);
    assign fs_lvl    = synced[1];
    assign sd_bit    = synced[2];

    // R8: a sampling edge can never be flagged on two adjacent cycles.
    a_r8_edge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        samp_edge |=> !samp_edge);

endmodule

// File: rtl/sar_frame_track.sv
// Tracks frame and slot boundaries at each sampling edge.
// It decides when a word starts and when the previous one closes.
// I2S and TDM look at the frame clock one edge late, so their one-bit MSB delay
// uses the same boundary logic as left-justified.
// Assumes SLOT_BITS is a power of two and the configuration is static.
module sar_frame_track
    import sar_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int MAX_SLOTS = 16,
    parameter int CHAN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_edge,
    input  logic              fs_lvl,
    input  fmt_e              mode,
    input  logic              fs_pol,
    input  logic              tdm16,
    output logic              word_start,
    output logic              word_close,
    output logic [CHAN_W-1:0] close_chan
);
    localparam int POS_W = $clog2(SLOT_BITS);
    localparam logic [CHAN_W-1:0] LAST_WIDE   = CHAN_W'(MAX_SLOTS - 1);
    localparam logic [CHAN_W-1:0] LAST_NARROW = CHAN_W'(MAX_SLOTS / 2 - 1);

    logic              primed, fs_d1, eff_prev, armed, over, cur_chan;
    logic [POS_W-1:0]  bitpos;
    logic [CHAN_W-1:0] slot, last_slot;
    logic              is_tdm, delay1, eff, changed, frame_go, slot_go, boundary;

    // Derives the effective frame level and the boundary events for this edge.
    always_comb begin
        is_tdm    = (mode == FMT_TDM);
        delay1    = (mode == FMT_I2S) || is_tdm;
        eff       = delay1 ? fs_d1 : fs_lvl;
        changed   = primed && (eff != eff_prev);
        frame_go  = is_tdm && changed && (eff == fs_pol);
        slot_go   = is_tdm && primed && armed && !frame_go && (bitpos == '0);
        last_slot = tdm16 ? LAST_WIDE : LAST_NARROW;
        boundary  = samp_edge && (is_tdm ? (frame_go || slot_go) : changed);
    end

    assign word_start = boundary;
    assign word_close = boundary && armed && !(is_tdm && over) && (mode != FMT_RSV);
    assign close_chan = is_tdm ? slot : CHAN_W'(cur_chan);

    // Updates the frame level history, slot position and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed   <= 1'b0;
            fs_d1    <= 1'b0;
            eff_prev <= 1'b0;
            armed    <= 1'b0;
            over     <= 1'b0;
            cur_chan <= 1'b0;
            bitpos   <= '0;
            slot     <= '0;
        end else if (samp_edge) begin
            fs_d1 <= fs_lvl;
            if (!primed) begin
                primed   <= 1'b1;
                eff_prev <= fs_lvl;
            end else begin
                eff_prev <= eff;
                if (is_tdm) begin
                    if (frame_go) begin
                        armed  <= 1'b1;
                        over   <= 1'b0;
                        slot   <= '0;
                        bitpos <= POS_W'(1);
                    end else begin
                        bitpos <= bitpos + 1'b1;
                        if (slot_go) begin
                            if (slot == last_slot) over <= 1'b1;
                            else                   slot <= slot + 1'b1;
                        end
                    end
                end else if (changed) begin
                    armed    <= 1'b1;
                    cur_chan <= eff ^ fs_pol;
                end
            end
        end
    end

    // R10: nothing can close before the first recording edge has been seen.
    a_r10_no_close_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> !word_close);

endmodule

// File: rtl/sar_word_shift.sv
// Shift engine shared by every format.
// It collects bits MSB first, then aligns the closed word and registers it as the output.
// Right-justified words keep shifting and take the last W bits. Other formats
// stop counting at DATA_W, so surplus bits are dropped.
module sar_word_shift
    import sar_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_edge,
    input  logic              sd_bit,
    input  logic              word_start,
    input  logic              word_close,
    input  logic [CHAN_W-1:0] close_chan,
    input  fmt_e              mode,
    output logic [DATA_W-1:0] smp_data,
    output logic [CHAN_W-1:0] smp_chan,
    output logic              smp_valid
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    logic [DATA_W-1:0] sh, mask, aligned;
    logic [CNT_W-1:0]  nbits, eff_n, pad;
    logic              rj;

    // Works out the word width and left-aligns the collected bits.
    always_comb begin
        rj      = is_rj(mode);
        eff_n   = rj ? CNT_W'(rj_width(mode)) : nbits;
        pad     = FULL - eff_n;
        mask    = {DATA_W{1'b1}} >> pad;
        aligned = (sh & mask) << pad;
    end

    // Shifts in one bit per sampling edge and restarts on a word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            nbits <= '0;
        end else if (samp_edge) begin
            if (word_start) begin
                sh    <= DATA_W'(sd_bit);
                nbits <= CNT_W'(1);
            end else if (rj) begin
                sh <= {sh[DATA_W-2:0], sd_bit};
            end else if (nbits < FULL) begin
                sh    <= {sh[DATA_W-2:0], sd_bit};
                nbits <= nbits + 1'b1;
            end
        end
    end

    // Registers the closed word and pulses the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data  <= '0;
            smp_chan  <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= word_close;
            if (word_close) begin
                smp_data <= aligned;
                smp_chan <= close_chan;
            end
        end
    end

    // R9: the strobe never lasts two cycles.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R4: a 16-bit right-justified word is padded with zeros below its LSB.
    a_r4_rj16_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode == FMT_RJ16) |-> (smp_data[DATA_W-17:0] == '0));

    // R11: the reserved code never strobes.
    a_r11_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (mode != FMT_RSV));

endmodule

// File: rtl/serial_audio_rx.sv
// Multi-format serial audio receiver: top level.
// Chains synchronizer, boundary tracker and shift engine.
// Assumes the configuration inputs change only while rst_n is low.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SLOT_BITS   = 32,
    parameter int MAX_SLOTS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cfg_mode,
    input  logic                         cfg_fs_pol,
    input  logic                         cfg_bclk_pol,
    input  logic                         cfg_tdm16,
    input  logic                         bclk_i,
    input  logic                         fsync_i,
    input  logic                         sdata_i,
    output logic [DATA_W-1:0]            smp_data,
    output logic [$clog2(MAX_SLOTS)-1:0] smp_chan,
    output logic                         smp_valid
);
    localparam int CHAN_W = $clog2(MAX_SLOTS);

    fmt_e              mode;
    logic              samp_edge, fs_lvl, sd_bit;
    logic              word_start, word_close;
    logic [CHAN_W-1:0] close_chan;

    assign mode = fmt_e'(cfg_mode);

    sar_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fs_i      (fsync_i),
        .sd_i      (sdata_i),
        .bclk_pol  (cfg_bclk_pol),
        .samp_edge (samp_edge),
        .fs_lvl    (fs_lvl),
        .sd_bit    (sd_bit)
    );

    sar_frame_track #(.SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS), .CHAN_W(CHAN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_edge  (samp_edge),
        .fs_lvl     (fs_lvl),
        .mode       (mode),
        .fs_pol     (cfg_fs_pol),
        .tdm16      (cfg_tdm16),
        .word_start (word_start),
        .word_close (word_close),
        .close_chan (close_chan)
    );

    sar_word_shift #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_edge  (samp_edge),
        .sd_bit     (sd_bit),
        .word_start (word_start),
        .word_close (word_close),
        .close_chan (close_chan),
        .mode       (mode),
        .smp_data   (smp_data),
        .smp_chan   (smp_chan),
        .smp_valid  (smp_valid)
    );

    // R5: outside TDM only channels 0 and 1 appear.
    a_r5_two_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode != FMT_TDM) |-> (smp_chan <= CHAN_W'(1)));

    // R7: an 8-slot frame never reports a slot above 7.
    a_r7_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode == FMT_TDM && !cfg_tdm16) |-> (smp_chan < CHAN_W'(MAX_SLOTS / 2)));

    // R10: the first cycle out of reset shows quiet outputs.
    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!smp_valid && smp_data == '0 && smp_chan == '0));

endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic cfg_fs_pol = 1'b0, cfg_bclk_pol = 1'b0, cfg_tdm16 = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
    logic [23:0] smp_data;
    logic [3:0]  smp_chan;
    logic        smp_valid;

    always #2.5 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fs_pol(cfg_fs_pol),
        .cfg_bclk_pol(cfg_bclk_pol), .cfg_tdm16(cfg_tdm16), .bclk_i(bclk),
        .fsync_i(fsync), .sdata_i(sdata), .smp_data(smp_data), .smp_chan(smp_chan),
        .smp_valid(smp_valid)
    );

    int checks = 0, errors = 0, got_n = 0, exp_n = 0, nb = 0, cyc = 0;
    bit done = 0, prev_v = 0;
    logic [23:0] got_d [64];
    logic [3:0]  got_c [64];
    logic [23:0] exp_d [32];
    logic [3:0]  exp_c [32];
    bit fsb [1024];
    bit sdb [1024];

    typedef struct packed {
        logic [2:0] mode;
        logic       fpol;
        logic       bpol;
        logic       t16;
        logic       pulse;
        logic       extra;
        logic [5:0] bph;
        logic [4:0] nslot;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0},  // R1 R5
        '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd24, 5'd0},  // R1 R5 R8, LSB on shared edge
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd32, 5'd0},  // R2 R4, surplus ones dropped
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd16, 5'd0},  // R2 R4 R5, short words
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0},  // R3
        '{3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0},  // R3 R8
        '{3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0},  // R3 R5
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0},  // R3 R4
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd8},  // R6 R7, 50/50 frame clock
        '{3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'd32, 5'd16}, // R6 R7 R8, pulse
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd32, 5'd10}, // R7, surplus slots
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd32, 5'd0}   // R11
    };

    function automatic string tagof(int t);
        case (t)
            0: return "R1/R5";       1: return "R1/R5/R8";
            2: return "R2/R4";       3: return "R2/R4/R5";
            4: return "R3";          5: return "R3/R8";
            6: return "R3/R5";       7: return "R3/R4";
            8: return "R6/R7";       9: return "R6/R7/R8";
            10: return "R7";         default: return "R11";
        endcase
    endfunction

    function automatic logic [23:0] wgen(int t, int k);
        return 24'((t + 1) * 32'h5A3C1 ^ (k + 3) * 32'h1B4E7);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Capture of strobed words and the R9 one-cycle rule, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid) begin
                checks++;
                if (prev_v) begin
                    errors++;
                    $display("FAIL R9 strobe on consecutive cycles actual=1 expected=0");
                end
                if (got_n < 64) begin
                    got_d[got_n] = smp_data;
                    got_c[got_n] = smp_chan;
                end
                got_n++;
            end
            prev_v = smp_valid;
        end else begin
            prev_v = 0;
        end
    end

    task automatic build(int t);
        vec_t v = VECS[t];
        int W;
        for (int i = 0; i < 1024; i++) begin fsb[i] = 0; sdb[i] = 0; end
        exp_n = 0;
        if (v.mode == 3'd2) begin
            int S = int'(v.nslot);
            int f0 = 4;
            int fe = f0 + 32 * S;
            int last = v.t16 ? 16 : 8;
            nb = fe + 10;
            for (int i = 0; i < nb; i++) begin
                bit act;
                if (i < f0)      act = 0;
                else if (i < fe) act = v.pulse ? (i == f0) : ((i - f0) < 16 * S);
                else             act = v.pulse ? (i == fe) : (i < fe + 8);
                fsb[i] = act ? v.fpol : !v.fpol;
            end
            for (int s = 0; s < S; s++) begin
                logic [23:0] w = wgen(t, s);
                for (int j = 0; j < 24; j++) sdb[f0 + 1 + 32 * s + j] = w[23 - j];
                if (s < last) begin
                    exp_d[exp_n] = w;
                    exp_c[exp_n] = 4'(s);
                    exp_n++;
                end
            end
        end else begin
            int B = int'(v.bph);
            int off;
            case (v.mode)
                3'd3: W = 24;  3'd4: W = 20;  3'd5: W = 18;  3'd6: W = 16;
                default: W = (B < 24) ? B : 24;
            endcase
            off = (v.mode == 3'd0) ? 1 : ((v.mode == 3'd1 || v.mode == 3'd7) ? 0 : B - W);
            nb = 8 * B;
            for (int i = 0; i < nb; i++) begin
                int hi = i / B;
                int ch = (hi == 0) ? 1 : ((hi - 1) % 2);
                fsb[i] = bit'(ch) ^ v.fpol;
            end
            for (int h = 0; h < 6; h++) begin
                logic [23:0] tw = wgen(t, h) >> (24 - W);
                int st = B * (h + 1) + off;
                for (int j = 0; j < W; j++) sdb[st + j] = tw[W - 1 - j];
                if (v.extra) for (int j = W; j < B; j++) sdb[st + j] = 1;
                if (v.mode != 3'd7) begin
                    exp_d[exp_n] = tw << (24 - W);
                    exp_c[exp_n] = 4'(h % 2);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_vec(int t);
        vec_t v = VECS[t];
        build(t);
        @(negedge clk);
        rst_n = 0;
        cfg_mode = v.mode; cfg_fs_pol = v.fpol; cfg_bclk_pol = v.bpol; cfg_tdm16 = v.t16;
        bclk = v.bpol; fsync = fsb[0]; sdata = 0;
        repeat (4) @(negedge clk);
        got_n = 0;
        rst_n = 1;
        for (int i = 0; i < nb; i++) begin
            bclk = v.bpol; fsync = fsb[i]; sdata = sdb[i];
            #20;
            bclk = !v.bpol;
            #20;
        end
        bclk = v.bpol;
        #200;
        check(tagof(t), "word count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n && k < 32; k++) begin
            check(tagof(t), $sformatf("word %0d data", k), 32'(got_d[k]), 32'(exp_d[k]));
            check(tagof(t), $sformatf("word %0d chan", k), 32'(got_c[k]), 32'(exp_c[k]));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000 && !done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: outputs quiet during and right after reset.
        repeat (4) @(negedge clk);
        check("R10", "valid in reset", 32'(smp_valid), 0);
        check("R10", "data in reset", 32'(smp_data), 0);
        rst_n = 1;
        @(negedge clk); @(negedge clk);
        check("R10", "chan after reset", 32'(smp_chan), 0);
        check("R10", "valid after reset", 32'(smp_valid), 0);

        for (int t = 0; t < NV; t++) run_vec(t);

        // R10: a held nonzero sample returns to zero under reset.
        run_vec(0);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        check("R10", "data cleared by reset", 32'(smp_data), 0);
        check("R10", "chan cleared by reset", 32'(smp_chan), 0);
        check("R10", "valid cleared by reset", 32'(smp_valid), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule